// File: doc/BRIEF.md
# I2C Status Flag Unit

This block keeps the read-only status byte of an I2C peripheral. It takes single-cycle event pulses from the serial engine, together with register access strobes and a few control bits from the software side. From these it sets and clears each status flag. It drives the status byte, an interrupt request and a request to hold the serial clock low while software still owes the peripheral a response.

Some flags clear only after two software accesses in order: a status read that sees the flag set, then a data-register access of the correct kind. Each of these flags has its own armed tracker. When the peripheral is disabled, every flag is cleared except the bus-activity flag, which keeps following the line conditions.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset `status_o` is 8'h00. Bit positions: 7 any-event, 6 always 0, 5 transmitted-byte, 4 bus-active, 3 byte-finished, 2 addressed, 1 master, 0 start-sent.
- R2: Bus-active (bit 4) sets on `ev_start_det` and clears on `ev_stop_det`, whether `periph_en` is 1 or 0.
- R3: While `periph_en` is 0, every bit except bit 4 reads 0 from the next cycle on, and no event or request sets them.
- R4: `ev_byte_done` with `byte_tx`=1 sets bit 3 and bit 5. With `byte_tx`=0 it sets bit 3 and clears bit 5, but only if `ack_en`=1. Otherwise the status does not change.
- R5: After a transmitted byte, bit 3 and bit 5 clear only when a `sr_rd` that sees bit 3 set is followed by `dr_wr`. A `dr_rd` in between disarms the sequence. Bit 3 remembers the direction of its byte even if bit 5 was cleared in the meantime.
- R6: After a received byte, bit 3 clears only when a `sr_rd` that sees it set is followed by `dr_rd`. A `dr_wr` leaves it set.
- R7: Bit 2 sets on `ev_addr_match` or `ev_gen_call` while `ack_en`=1, and clears on the cycle after a `sr_rd` that sees it set.
- R8: Bit 0 sets on `ev_start_gen` and clears on a `sr_rd` that sees it, followed by `dr_wr`. A `dr_wr` without that read leaves it set.
- R9: Bit 1 sets on `start_req` and clears on `ev_stop_det` or `ev_arb_lost`. Both of those events also clear bit 5.
- R10: Bit 7 is 1 while bit 3, 2 or 0 is set, or while an event notice is pending. A notice is recorded on `ev_nack`, `ev_bus_err`, `ev_arb_lost`, `ev_addr_sent`, or `ev_stop_det` when bit 1 is 0. It is removed by `sr_rd`.
- R11: `scl_hold_o` is 1 exactly while bit 3 or bit 2 is set.
- R12: `irq_o` is `irq_en` AND (bit 3 OR bit 2 OR bit 0). With IRQ_REG=0 it follows in the same cycle as the flags; with IRQ_REG=1 it follows one cycle later.
- R13: An event that sets a flag wins over a clearing access in the same cycle. Any event pulse arriving between the status read and the data access disarms the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_byte_done | input | 1 | Byte and its acknowledge slot finished |
| byte_tx | input | 1 | Direction of the finished byte, 1 = transmitted |
| ev_addr_match | input | 1 | Own slave address recognised |
| ev_gen_call | input | 1 | General call address recognised |
| ev_start_gen | input | 1 | Start condition generated by this master |
| ev_start_det | input | 1 | Start condition seen on the bus |
| ev_stop_det | input | 1 | Stop condition seen on the bus |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_nack | input | 1 | No acknowledge after a transmitted byte |
| ev_bus_err | input | 1 | Misplaced start or stop |
| ev_addr_sent | input | 1 | Master address byte sent successfully |
| ack_en | input | 1 | Acknowledge enable |
| start_req | input | 1 | Software request for a start |
| periph_en | input | 1 | Peripheral enable |
| irq_en | input | 1 | Interrupt enable |
| sr_rd | input | 1 | Status register read strobe |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Hold serial clock low |

## Verification
The bench builds the block with IRQ_REG=0, so the interrupt line can be compared against the flags in the same cycle as the status byte. That setting lets each two-step clear sequence be checked access by access: wrong access kinds, events that disarm a sequence, coincident set and clear, and disable in the middle of a transfer. The registered interrupt variant is covered only by its checker property.

// File: rtl/i2c_stat_pkg.sv
`timescale 1ns/1ps
package i2c_stat_pkg;
   localparam int unsigned STAT_W = 8;
   localparam int unsigned N_ARM  = 2;
   localparam int unsigned ARM_SB  = 0;
   localparam int unsigned ARM_BTF = 1;

   // layout MSB to LSB; software decodes these positions
   typedef struct packed {
      logic evf;
      logic rsv;
      logic tra;
      logic busy;
      logic btf;
      logic adsl;
      logic msl;
      logic sb;
   } stat_t;

   typedef struct packed {
      logic byte_done;
      logic byte_tx;
      logic addr_match;
      logic gen_call;
      logic start_gen;
      logic start_det;
      logic stop_det;
      logic arb_lost;
      logic nack;
      logic bus_err;
      logic addr_sent;
   } hw_ev_t;
endpackage

// File: rtl/i2c_stat_arm.sv
`timescale 1ns/1ps
module i2c_stat_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic flag,
   input  logic want_wr,
   input  logic sr_rd,
   input  logic dr_rd,
   input  logic dr_wr,
   input  logic any_ev,
   output logic clr
);
   logic armed_q, armed_d;

   always_comb begin
      armed_d = armed_q;
      if (!en || !flag)                  armed_d = 1'b0;
      else if (sr_rd)                    armed_d = 1'b1;
      else if (dr_rd || dr_wr || any_ev) armed_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end

   assign clr = armed_q && flag && !sr_rd && (want_wr ? dr_wr : dr_rd);
endmodule

// File: rtl/i2c_stat_xfer.sv
`timescale 1ns/1ps
module i2c_stat_xfer (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic byte_done,
   input  logic byte_tx,
   input  logic ack_en,
   input  logic stop_det,
   input  logic arb_lost,
   input  logic clr,
   output logic btf,
   output logic tra,
   output logic dir_tx
);
   logic btf_q, tra_q, dir_q;
   logic btf_set;

   assign btf_set = en && byte_done && (byte_tx || ack_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         btf_q <= 1'b0;
         tra_q <= 1'b0;
         dir_q <= 1'b0;
      end else if (!en) begin
         btf_q <= 1'b0;
         tra_q <= 1'b0;
         dir_q <= 1'b0;
      end else if (btf_set) begin
         btf_q <= 1'b1;
         tra_q <= byte_tx;
         dir_q <= byte_tx;
      end else begin
         if (clr) btf_q <= 1'b0;
         if (clr || stop_det || arb_lost) tra_q <= 1'b0;
      end
   end

   assign btf    = btf_q;
   assign tra    = tra_q;
   assign dir_tx = dir_q;
endmodule

// File: rtl/i2c_stat_mode.sv
`timescale 1ns/1ps
module i2c_stat_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ack_en,
   input  logic start_req,
   input  logic sr_rd,
   input  logic sb_clr,
   input  i2c_stat_pkg::hw_ev_t ev,
   output logic sb,
   output logic adsl,
   output logic msl,
   output logic note
);
   logic sb_q, adsl_q, msl_q, note_q;
   logic adsl_set, note_set;

   assign adsl_set = ack_en && (ev.addr_match || ev.gen_call);
   assign note_set = ev.nack || ev.bus_err || ev.arb_lost || ev.addr_sent
                     || (ev.stop_det && !msl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sb_q   <= 1'b0;
         adsl_q <= 1'b0;
         msl_q  <= 1'b0;
         note_q <= 1'b0;
      end else if (!en) begin
         sb_q   <= 1'b0;
         adsl_q <= 1'b0;
         msl_q  <= 1'b0;
         note_q <= 1'b0;
      end else begin
         if (ev.start_gen)   sb_q <= 1'b1;
         else if (sb_clr)    sb_q <= 1'b0;

         if (adsl_set)                 adsl_q <= 1'b1;
         else if (sr_rd && adsl_q)     adsl_q <= 1'b0;

         if (start_req)                        msl_q <= 1'b1;
         else if (ev.stop_det || ev.arb_lost)  msl_q <= 1'b0;

         if (note_set)    note_q <= 1'b1;
         else if (sr_rd)  note_q <= 1'b0;
      end
   end

   assign sb   = sb_q;
   assign adsl = adsl_q;
   assign msl  = msl_q;
   assign note = note_q;
endmodule

// File: rtl/i2c_stat_irq.sv
`timescale 1ns/1ps
module i2c_stat_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_en,
   input  logic btf,
   input  logic adsl,
   input  logic sb,
   output logic irq
);
   logic req;
   assign req = irq_en && (btf || adsl || sb);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= req;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = req;
      end
   endgenerate
endmodule

// File: rtl/i2c_stat_flags.sv
`timescale 1ns/1ps
module i2c_stat_flags #(
   parameter int unsigned STAT_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_byte_done,
   input  logic              byte_tx,
   input  logic              ev_addr_match,
   input  logic              ev_gen_call,
   input  logic              ev_start_gen,
   input  logic              ev_start_det,
   input  logic              ev_stop_det,
   input  logic              ev_arb_lost,
   input  logic              ev_nack,
   input  logic              ev_bus_err,
   input  logic              ev_addr_sent,
   input  logic              ack_en,
   input  logic              start_req,
   input  logic              periph_en,
   input  logic              irq_en,
   input  logic              sr_rd,
   input  logic              dr_rd,
   input  logic              dr_wr,
   output logic [STAT_W-1:0] status_o,
   output logic              irq_o,
   output logic              scl_hold_o
);
   import i2c_stat_pkg::*;

   generate
      if (STAT_W != i2c_stat_pkg::STAT_W) begin : g_bad_width
         $error("status width must match the package layout");
      end
   endgenerate

   hw_ev_t ev;
   logic   any_ev;
   logic   busy_q;
   logic   btf, tra, dir_tx, sb, adsl, msl, note;
   logic [N_ARM-1:0] arm_flag, arm_wr, arm_clr;
   stat_t  st;

   assign ev = '{byte_done: ev_byte_done, byte_tx: byte_tx,
                 addr_match: ev_addr_match, gen_call: ev_gen_call,
                 start_gen: ev_start_gen, start_det: ev_start_det,
                 stop_det: ev_stop_det, arb_lost: ev_arb_lost,
                 nack: ev_nack, bus_err: ev_bus_err, addr_sent: ev_addr_sent};

   assign any_ev = ev_byte_done | ev_addr_match | ev_gen_call | ev_start_gen
                 | ev_start_det | ev_stop_det | ev_arb_lost | ev_nack
                 | ev_bus_err | ev_addr_sent;

   // bus activity tracks the line regardless of enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy_q <= 1'b0;
      else if (ev_start_det) busy_q <= 1'b1;
      else if (ev_stop_det)  busy_q <= 1'b0;
   end

   assign arm_flag[ARM_SB]  = sb;
   assign arm_wr[ARM_SB]    = 1'b1;
   assign arm_flag[ARM_BTF] = btf;
   assign arm_wr[ARM_BTF]   = dir_tx;

   generate
      for (genvar i = 0; i < N_ARM; i++) begin : g_arm
         i2c_stat_arm u_arm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (periph_en),
            .flag    (arm_flag[i]),
            .want_wr (arm_wr[i]),
            .sr_rd   (sr_rd),
            .dr_rd   (dr_rd),
            .dr_wr   (dr_wr),
            .any_ev  (any_ev),
            .clr     (arm_clr[i])
         );
      end
   endgenerate

   i2c_stat_xfer u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (periph_en),
      .byte_done (ev_byte_done),
      .byte_tx   (byte_tx),
      .ack_en    (ack_en),
      .stop_det  (ev_stop_det),
      .arb_lost  (ev_arb_lost),
      .clr       (arm_clr[ARM_BTF]),
      .btf       (btf),
      .tra       (tra),
      .dir_tx    (dir_tx)
   );

   i2c_stat_mode u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (periph_en),
      .ack_en    (ack_en),
      .start_req (start_req),
      .sr_rd     (sr_rd),
      .sb_clr    (arm_clr[ARM_SB]),
      .ev        (ev),
      .sb        (sb),
      .adsl      (adsl),
      .msl       (msl),
      .note      (note)
   );

   i2c_stat_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_en (irq_en),
      .btf    (btf),
      .adsl   (adsl),
      .sb     (sb),
      .irq    (irq_o)
   );

   always_comb begin
      st      = '0;
      st.evf  = note | btf | adsl | sb;
      st.tra  = tra;
      st.busy = busy_q;
      st.btf  = btf;
      st.adsl = adsl;
      st.msl  = msl;
      st.sb   = sb;
   end

   assign status_o   = st;
   assign scl_hold_o = btf | adsl;
endmodule

// File: rtl/i2c_stat_flags_chk.sv
`timescale 1ns/1ps
module i2c_stat_flags_chk #(
   parameter int unsigned STAT_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_byte_done,
   input logic              byte_tx,
   input logic              ev_addr_match,
   input logic              ev_gen_call,
   input logic              ev_start_gen,
   input logic              ev_start_det,
   input logic              ev_stop_det,
   input logic              ev_arb_lost,
   input logic              start_req,
   input logic              periph_en,
   input logic              irq_en,
   input logic              sr_rd,
   input logic [STAT_W-1:0] status_o,
   input logic              irq_o,
   input logic              scl_hold_o
);
   assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start_det |=> status_o[4]);
   assert_busy_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop_det && !ev_start_det) |=> !status_o[4]);
   assert_off_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |=> ((status_o & 8'hEF) == 8'h00));
   assert_btf_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en && ev_byte_done && byte_tx) |=> (status_o[3] && status_o[5]));
   assert_adsl_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en && sr_rd && !ev_addr_match && !ev_gen_call) |=> !status_o[2]);
   assert_sb_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en && ev_start_gen) |=> status_o[0]);
   assert_msl_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en && (ev_stop_det || ev_arb_lost) && !start_req) |=> !status_o[1]);
   assert_hold_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en && ev_byte_done && byte_tx) |=> scl_hold_o);
   assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |=> !scl_hold_o);

   generate
      if (IRQ_REG) begin : g_reg
         assert_irq_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |=> !irq_o);
      end else begin : g_comb
         assert_irq_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |-> !irq_o);
      end
   endgenerate
endmodule

bind i2c_stat_flags i2c_stat_flags_chk #(.STAT_W(STAT_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_byte_done  (ev_byte_done),
   .byte_tx       (byte_tx),
   .ev_addr_match (ev_addr_match),
   .ev_gen_call   (ev_gen_call),
   .ev_start_gen  (ev_start_gen),
   .ev_start_det  (ev_start_det),
   .ev_stop_det   (ev_stop_det),
   .ev_arb_lost   (ev_arb_lost),
   .start_req     (start_req),
   .periph_en     (periph_en),
   .irq_en        (irq_en),
   .sr_rd         (sr_rd),
   .status_o      (status_o),
   .irq_o         (irq_o),
   .scl_hold_o    (scl_hold_o)
);

// File: tb/i2c_stat_flags_tb_top.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb_top;
   typedef struct {
      logic [7:0] st;
      logic       irq;
      logic       hold;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_byte_done = 0, byte_tx = 0, ev_addr_match = 0, ev_gen_call = 0;
   logic ev_start_gen = 0, ev_start_det = 0, ev_stop_det = 0, ev_arb_lost = 0;
   logic ev_nack = 0, ev_bus_err = 0, ev_addr_sent = 0;
   logic ack_en = 1, start_req = 0, periph_en = 1, irq_en = 1;
   logic sr_rd = 0, dr_rd = 0, dr_wr = 0;
   logic [7:0] status_o;
   logic irq_o, scl_hold_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t sbq[$];

   always #2.5 clk = ~clk;

   i2c_stat_flags #(.STAT_W(8), .IRQ_REG(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ev_byte_done(ev_byte_done), .byte_tx(byte_tx),
      .ev_addr_match(ev_addr_match), .ev_gen_call(ev_gen_call),
      .ev_start_gen(ev_start_gen), .ev_start_det(ev_start_det),
      .ev_stop_det(ev_stop_det), .ev_arb_lost(ev_arb_lost),
      .ev_nack(ev_nack), .ev_bus_err(ev_bus_err), .ev_addr_sent(ev_addr_sent),
      .ack_en(ack_en), .start_req(start_req), .periph_en(periph_en),
      .irq_en(irq_en), .sr_rd(sr_rd), .dr_rd(dr_rd), .dr_wr(dr_wr),
      .status_o(status_o), .irq_o(irq_o), .scl_hold_o(scl_hold_o)
   );

   // monitor: compares one item per clock edge, after the edge settles
   always @(posedge clk) begin
      #1;
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         checks++;
         if (status_o !== e.st || irq_o !== e.irq || scl_hold_o !== e.hold) begin
            errors++;
            $display("FAIL %s: status=%02h irq=%0b hold=%0b expected status=%02h irq=%0b hold=%0b",
                     e.tag, status_o, irq_o, scl_hold_o, e.st, e.irq, e.hold);
         end
      end
   end

   task automatic quiet();
      ev_byte_done = 0; ev_addr_match = 0; ev_gen_call = 0; ev_start_gen = 0;
      ev_start_det = 0; ev_stop_det = 0; ev_arb_lost = 0; ev_nack = 0;
      ev_bus_err = 0; ev_addr_sent = 0; start_req = 0;
      sr_rd = 0; dr_rd = 0; dr_wr = 0; byte_tx = 0;
   endtask

   // driver: inputs already set at the falling edge; queue the result of the next edge
   task automatic cyc(input logic [7:0] st, input logic irq, input logic hold, input string tag);
      exp_t e;
      e.st = st; e.irq = irq; e.hold = hold; e.tag = tag;
      sbq.push_back(e);
      @(posedge clk);
      @(negedge clk);
      quiet();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      quiet();
      repeat (3) @(negedge clk);
      checks++;
      if (status_o !== 8'h00 || irq_o !== 1'b0 || scl_hold_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: status=%02h expected 00", status_o);
      end
      rst_n = 1'b1;
      @(negedge clk);

      cyc(8'h00, 0, 0, "R1 idle after reset");
      ev_start_det = 1;               cyc(8'h10, 0, 0, "R2 start seen");
      start_req = 1;                  cyc(8'h12, 0, 0, "R9 master set");
      ev_start_gen = 1;               cyc(8'h93, 1, 0, "R8 start sent");
      dr_wr = 1;                      cyc(8'h93, 1, 0, "R8 write without read");
      sr_rd = 1;                      cyc(8'h93, 1, 0, "R8 armed");
      dr_wr = 1;                      cyc(8'h12, 0, 0, "R8 cleared");
      ev_addr_sent = 1;               cyc(8'h92, 0, 0, "R10 address sent notice");
      sr_rd = 1;                      cyc(8'h12, 0, 0, "R10 notice read");

      ev_byte_done = 1; byte_tx = 1;  cyc(8'hBA, 1, 1, "R4 tx byte");
      sr_rd = 1;                      cyc(8'hBA, 1, 1, "R5 armed");
      dr_rd = 1;                      cyc(8'hBA, 1, 1, "R5 wrong read");
      dr_wr = 1;                      cyc(8'hBA, 1, 1, "R5 disarmed write");
      sr_rd = 1;                      cyc(8'hBA, 1, 1, "R5 rearmed");
      dr_wr = 1;                      cyc(8'h12, 0, 0, "R5 tx cleared");

      ev_byte_done = 1; byte_tx = 0;  cyc(8'h9A, 1, 1, "R4 rx byte");
      sr_rd = 1;                      cyc(8'h9A, 1, 1, "R6 armed");
      dr_wr = 1;                      cyc(8'h9A, 1, 1, "R6 wrong write");
      sr_rd = 1;                      cyc(8'h9A, 1, 1, "R6 rearmed");
      dr_rd = 1;                      cyc(8'h12, 0, 0, "R6 rx cleared");
      ack_en = 0; ev_byte_done = 1;   cyc(8'h12, 0, 0, "R4 rx without ack");
      ack_en = 1;

      ev_byte_done = 1; byte_tx = 1;  cyc(8'hBA, 1, 1, "R13 setup");
      sr_rd = 1;                      cyc(8'hBA, 1, 1, "R13 armed");
      dr_wr = 1; ev_byte_done = 1; byte_tx = 1;
                                      cyc(8'hBA, 1, 1, "R13 event wins");
      sr_rd = 1;                      cyc(8'hBA, 1, 1, "R13 armed again");
      ev_nack = 1;                    cyc(8'hBA, 1, 1, "R13 event disarms");
      dr_wr = 1;                      cyc(8'hBA, 1, 1, "R13 disarmed write");
      sr_rd = 1;                      cyc(8'hBA, 1, 1, "R13 rearm");
      dr_wr = 1;                      cyc(8'h12, 0, 0, "R13 cleared");

      irq_en = 0; ev_byte_done = 1; byte_tx = 1;
                                      cyc(8'hBA, 0, 1, "R12 masked irq");
      sr_rd = 1;                      cyc(8'hBA, 0, 1, "R12 masked armed");
      dr_wr = 1;                      cyc(8'h12, 0, 0, "R12 masked clear");
      irq_en = 1;

      ev_addr_match = 1;              cyc(8'h96, 1, 1, "R7 address match");
      sr_rd = 1;                      cyc(8'h12, 0, 0, "R7 read clears");
      ev_gen_call = 1;                cyc(8'h96, 1, 1, "R7 general call");
      sr_rd = 1;                      cyc(8'h12, 0, 0, "R7 read clears");
      ack_en = 0; ev_addr_match = 1;  cyc(8'h12, 0, 0, "R7 match without ack");
      ack_en = 1;
      ev_addr_match = 1; sr_rd = 1;   cyc(8'h96, 1, 1, "R13 match beats read");
      sr_rd = 1;                      cyc(8'h12, 0, 0, "R7 read clears");

      ev_byte_done = 1; byte_tx = 1;  cyc(8'hBA, 1, 1, "R9 setup");
      ev_arb_lost = 1;                cyc(8'h98, 1, 1, "R9 arbitration lost");
      sr_rd = 1;                      cyc(8'h98, 1, 1, "R5 armed after loss");
      dr_wr = 1;                      cyc(8'h10, 0, 0, "R5 direction kept");
      ev_stop_det = 1;                cyc(8'h80, 0, 0, "R10 slave stop");
      sr_rd = 1;                      cyc(8'h00, 0, 0, "R10 notice read");
      ev_start_det = 1;               cyc(8'h10, 0, 0, "R2 start seen");
      start_req = 1;                  cyc(8'h12, 0, 0, "R9 master set");
      ev_stop_det = 1;                cyc(8'h00, 0, 0, "R9 master stop");
      ev_bus_err = 1;                 cyc(8'h80, 0, 0, "R10 bus error");
      sr_rd = 1;                      cyc(8'h00, 0, 0, "R10 notice read");

      ev_start_det = 1;               cyc(8'h10, 0, 0, "R2 start seen");
      start_req = 1;                  cyc(8'h12, 0, 0, "R9 master set");
      ev_start_gen = 1;               cyc(8'h93, 1, 0, "R8 start sent");
      periph_en = 0;                  cyc(8'h10, 0, 0, "R3 disable clears");
      ev_byte_done = 1; byte_tx = 1;  cyc(8'h10, 0, 0, "R3 byte ignored");
      start_req = 1;                  cyc(8'h10, 0, 0, "R3 request ignored");
      ev_stop_det = 1;                cyc(8'h00, 0, 0, "R2 stop while off");
      ev_start_det = 1;               cyc(8'h10, 0, 0, "R2 start while off");
      periph_en = 1;                  cyc(8'h10, 0, 0, "R3 enabled again");
      sr_rd = 1;                      cyc(8'h10, 0, 0, "R10 no notice from off");

      repeat (2) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule